// File: doc/BRIEF.md
# Bidirectional Sampling Pulse Sequencer

This block produces the per-channel sample strobes for a column driver with 240 outputs. The outputs form 80 groups, and each group has three sub-channels, A, B and C. A start pulse arrives on one of two cascade pins. A direction input decides which pin takes the start and which pin passes a carry on to the next chip. When the direction is reversed, the whole scan order is mirrored.

A mode input picks one of two scan styles. In group mode, all three sub-channels of a group are strobed together on one clock. In single mode, one sub-channel is strobed per clock. The two modes have different start latencies. After the last position is strobed, the sequencer parks itself until a new start arrives. One clock before the last position is loaded, it raises a one-cycle carry, so a chained chip continues the scan without a gap.

A bank-select input swaps the roles of the two hold banks. The block decodes this input into one-hot drive and sample selects. It also flags any change of the bank-select input while a scan is running.

Top module: `sample_pulse_seq`

## Requirements
- R1: The strobe vector has NUM_GROUPS*3 bits. Bit 3*(g-1)+s belongs to group g (1-based) and sub-channel s, where A=0, B=1 and C=2.
- R2: While dirFwd is high, leftIn is the start input and rightOut/rightOe carry the pulse out (leftOe=0, rightOe=1). While dirFwd is low, the roles swap (leftOe=1, rightOe=0). An output pin is low whenever its enable is low.
- R3: In group mode (modeGroup=1), suppose a start is captured at edge E. Then group 1 (bits 0..2) is strobed for the cycle after edge E+1 in forward direction, or group 80 (bits 237..239) in reverse direction. Each later edge moves the strobe by one group.
- R4: In single mode (modeGroup=0), suppose a start is captured at edge E. Then no strobe is active until edge E+3, which loads the first sub-channel.
- R5: In single mode, one bit advances per clock. Forward order is bit 0 up to bit 239 (A1, B1, C1, A2 and so on). Reverse order is bit 239 down to bit 0 (C80, B80, A80, C79 and so on).
- R6: After the final position has been shown for one cycle, all strobes go low. They stay low, whatever the clock does, until a new start is captured.
- R7: The carry goes high for exactly one cycle, which is the cycle just before the final position is shown. It appears on the output pin chosen by R2.
- R8: driveBank is 2'b01 (bank 1 drives) and sampleBank is 2'b10 when bankSel is low. The two values swap when bankSel is high.
- R9: Suppose bankSel differs at an edge from its value at the previous edge while a scan is active. Then bankErr is high for the following cycle. Otherwise bankErr is low.
- R10: A start pulse that arrives while a scan is active (including its lead-in) has no effect on the strobes or the carry. The same holds for a pulse on the pin that is currently the output pin.
- R11: A synchronous active-low reset clears all strobes, the carry and bankErr, and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| dirFwd | input | 1 | Scan direction: 1 = forward, 0 = reverse |
| modeGroup | input | 1 | 1 = strobe three sub-channels at once, 0 = one at a time |
| bankSel | input | 1 | Hold bank role select |
| leftIn | input | 1 | Left cascade pin, input side |
| leftOut | output | 1 | Left cascade pin, output side (carry in reverse direction) |
| leftOe | output | 1 | Left cascade pin output enable |
| rightIn | input | 1 | Right cascade pin, input side |
| rightOut | output | 1 | Right cascade pin, output side (carry in forward direction) |
| rightOe | output | 1 | Right cascade pin output enable |
| strobe | output | NUM_GROUPS*3 | Per-channel sample strobes |
| driveBank | output | 2 | One-hot bank that drives the column outputs |
| sampleBank | output | 2 | One-hot bank that samples |
| bankErr | output | 1 | Bank-select changed during a scan |

## Verification
The bench builds the block with its default of 80 groups, which gives the full 240-bit strobe vector. With that size, both end positions, the mirrored reverse order and the carry before the last group or sub-channel can all be seen exactly as a full-size chip would show them. A full single-mode scan takes about 243 clocks, so every mode and direction, restarts with the start held high, an interrupting reset and bank changes during a scan all fit easily within the run.

// File: rtl/sps_pkg.sv
package sps_pkg;

  // Strobes from the control to the shift datapath
  typedef struct packed {
    logic load;       // load the first scan position
    logic shift;      // advance one position
    logic clear;      // drop all strobes
    logic groupMode;  // latched scan style
    logic fwd;        // latched scan direction
  } stepCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2
  } seqState_t;

endpackage

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
#(
  parameter int NUM_GROUPS = 80,
  parameter int SUBS       = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startIn,
  input  logic     modeGroup,
  input  logic     dirFwd,
  input  logic     bankSel,
  output stepCtl_t ctl,
  output logic     busy,
  output logic     carry,
  output logic     bankErr
);

  localparam int TOTAL       = NUM_GROUPS * SUBS;
  localparam int CW          = $clog2(TOTAL + 1);
  localparam int LEAD_SINGLE = 3;

  seqState_t      state, stateNext;
  logic [1:0]     leadCnt, leadNext;
  logic [CW-1:0]  remain, remainNext;
  logic           groupQ, fwdQ, carryQ, bankSelQ, errQ;

  always_comb begin
    stateNext     = state;
    leadNext      = leadCnt;
    remainNext    = remain;
    ctl           = '0;
    ctl.groupMode = groupQ;
    ctl.fwd       = fwdQ;
    case (state)
      ST_IDLE: begin
        if (startIn) begin
          stateNext = ST_LEAD;
          leadNext  = modeGroup ? 2'd0 : 2'(LEAD_SINGLE - 1);
        end
      end
      ST_LEAD: begin
        if (leadCnt == 2'd0) begin
          ctl.load   = 1'b1;
          stateNext  = ST_RUN;
          remainNext = groupQ ? CW'(NUM_GROUPS - 1) : CW'(TOTAL - 1);
        end else begin
          leadNext = leadCnt - 2'd1;
        end
      end
      ST_RUN: begin
        if (remain == '0) begin
          ctl.clear = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          ctl.shift  = 1'b1;
          remainNext = remain - CW'(1);
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      leadCnt  <= 2'd0;
      remain   <= '0;
      groupQ   <= 1'b0;
      fwdQ     <= 1'b1;
      carryQ   <= 1'b0;
      bankSelQ <= bankSel;
      errQ     <= 1'b0;
    end else begin
      state    <= stateNext;
      leadCnt  <= leadNext;
      remain   <= remainNext;
      if (state == ST_IDLE && startIn) begin
        groupQ <= modeGroup;
        fwdQ   <= dirFwd;
      end
      carryQ   <= (stateNext == ST_RUN) && (remainNext == CW'(1));
      errQ     <= (state != ST_IDLE) && (bankSel != bankSelQ);
      bankSelQ <= bankSel;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign carry   = carryQ;
  assign bankErr = errQ;

  AST_CARRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    carry |=> !carry);  // R7
  AST_BANK_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && busy && (bankSel != $past(bankSel))) |=> bankErr);  // R9
  AST_NO_FLAG_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> !bankErr);  // R9

endmodule

// File: rtl/sps_datapath.sv
module sps_datapath
  import sps_pkg::*;
#(
  parameter int NUM_GROUPS = 80,
  parameter int SUBS       = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  stepCtl_t                    ctl,
  output logic [NUM_GROUPS*SUBS-1:0]  strobe
);

  localparam int TOTAL = NUM_GROUPS * SUBS;

  logic [TOTAL-1:0] seedFwd, seedRev, seed, shifted;

  // First position of a scan, built per bit
  for (genvar i = 0; i < TOTAL; i++) begin : g_seed
    if (i < SUBS) begin : g_lo
      assign seedFwd[i] = ctl.groupMode || (i == 0);
    end else begin : g_lo0
      assign seedFwd[i] = 1'b0;
    end
    if (i >= TOTAL - SUBS) begin : g_hi
      assign seedRev[i] = ctl.groupMode || (i == TOTAL - 1);
    end else begin : g_hi0
      assign seedRev[i] = 1'b0;
    end
  end

  always_comb begin
    seed = ctl.fwd ? seedFwd : seedRev;
    if (ctl.fwd)
      shifted = ctl.groupMode ? (strobe << SUBS) : (strobe << 1);
    else
      shifted = ctl.groupMode ? (strobe >> SUBS) : (strobe >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          strobe <= '0;
    else if (ctl.clear) strobe <= '0;
    else if (ctl.load)  strobe <= seed;
    else if (ctl.shift) strobe <= shifted;
  end

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe != '0) |-> ($countones(strobe) == (ctl.groupMode ? SUBS : 1)));  // R3

endmodule

// File: rtl/sample_pulse_seq.sv
module sample_pulse_seq
  import sps_pkg::*;
#(
  parameter int NUM_GROUPS = 80,
  parameter int SUBS       = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        dirFwd,
  input  logic                        modeGroup,
  input  logic                        bankSel,
  input  logic                        leftIn,
  output logic                        leftOut,
  output logic                        leftOe,
  input  logic                        rightIn,
  output logic                        rightOut,
  output logic                        rightOe,
  output logic [NUM_GROUPS*SUBS-1:0]  strobe,
  output logic [1:0]                  driveBank,
  output logic [1:0]                  sampleBank,
  output logic                        bankErr
);

  localparam int TOTAL = NUM_GROUPS * SUBS;

  stepCtl_t ctl;
  logic     startIn, busy, carry;

  assign startIn = dirFwd ? leftIn : rightIn;

  sps_ctrl #(.NUM_GROUPS(NUM_GROUPS), .SUBS(SUBS)) uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .modeGroup(modeGroup),
    .dirFwd(dirFwd), .bankSel(bankSel), .ctl(ctl), .busy(busy),
    .carry(carry), .bankErr(bankErr)
  );

  sps_datapath #(.NUM_GROUPS(NUM_GROUPS), .SUBS(SUBS)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .strobe(strobe)
  );

  assign leftOe     = !dirFwd;
  assign rightOe    = dirFwd;
  assign leftOut    = !dirFwd && carry;
  assign rightOut   = dirFwd && carry;
  assign driveBank  = bankSel ? 2'b10 : 2'b01;
  assign sampleBank = ~driveBank;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (strobe == '0));  // R6
  AST_CARRY_BEFORE_LAST: assert property (@(posedge clk) disable iff (!rstN)
    carry |=> (strobe[0] || strobe[TOTAL-1]));  // R7
  AST_PIN_DRIVEN_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (leftOut |-> leftOe) and (rightOut |-> rightOe));  // R2

endmodule

// File: tb/sample_pulse_seq_test.sv
`timescale 1ns/1ps
module sample_pulse_seq_test;

  localparam int NG    = 80;
  localparam int TOTAL = NG * 3;

  logic clk = 1'b0;
  logic rstN, dirFwd, modeGroup, bankSel, leftIn, rightIn;
  logic leftOut, leftOe, rightOut, rightOe, bankErr;
  logic [TOTAL-1:0] strobe;
  logic [1:0] driveBank, sampleBank;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;  // 50 MHz

  sample_pulse_seq #(.NUM_GROUPS(NG)) uut (
    .clk(clk), .rstN(rstN), .dirFwd(dirFwd), .modeGroup(modeGroup),
    .bankSel(bankSel), .leftIn(leftIn), .leftOut(leftOut), .leftOe(leftOe),
    .rightIn(rightIn), .rightOut(rightOut), .rightOe(rightOe),
    .strobe(strobe), .driveBank(driveBank), .sampleBank(sampleBank),
    .bankErr(bankErr)
  );

  // Behavioural reference: 0 idle, 1 lead-in, 2 scanning
  int mState = 0, mCnt = 0, mPos = 0;
  bit mGroup = 0, mFwd = 1, mCarry = 0, mErr = 0, mPrevBank = 0;

  always @(posedge clk) begin
    bit st;
    int steps;
    if (!rstN) begin
      mState = 0; mCarry = 0; mErr = 0; mPrevBank = bankSel;
    end else begin
      st = dirFwd ? leftIn : rightIn;
      mErr = (mState != 0) && (bankSel != mPrevBank);
      mPrevBank = bankSel;
      steps = mGroup ? NG : TOTAL;
      case (mState)
        0: if (st) begin
             mState = 1; mGroup = modeGroup; mFwd = dirFwd;
             mCnt = modeGroup ? 0 : 2;
           end
        1: if (mCnt == 0) begin mState = 2; mPos = 0; end
           else mCnt--;
        default: if (mPos == steps - 1) mState = 0; else mPos++;
      endcase
      steps = mGroup ? NG : TOTAL;
      mCarry = (mState == 2) && (mPos == steps - 2);
    end
  end

  function automatic logic [TOTAL-1:0] expStrobe();
    logic [TOTAL-1:0] v = '0;
    int g;
    if (mState == 2) begin
      if (mGroup) begin
        g = mFwd ? mPos : NG - 1 - mPos;
        for (int s = 0; s < 3; s++) v[3*g + s] = 1'b1;  // R1 bit layout
      end else begin
        v[mFwd ? mPos : TOTAL - 1 - mPos] = 1'b1;
      end
    end
    return v;
  endfunction

  task automatic chk(string req, logic [TOTAL-1:0] act, logic [TOTAL-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compareAll();
    string sTag;
    if (!rstN) sTag = "R11";
    else if (mState == 0) sTag = "R6";
    else if (mState == 1) sTag = mGroup ? "R3" : "R4";
    else sTag = mGroup ? "R3" : "R5";
    chk(sTag, strobe, expStrobe());
    chk("R2", TOTAL'({leftOe, rightOe}), TOTAL'({!dirFwd, dirFwd}));
    chk("R7", TOTAL'({leftOut, rightOut}),
        TOTAL'({mCarry && !dirFwd, mCarry && dirFwd}));
    chk("R8", TOTAL'({driveBank, sampleBank}),
        TOTAL'(bankSel ? 4'b1001 : 4'b0110));
    chk("R9", TOTAL'(bankErr), TOTAL'(mErr));
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic pulse(bit onLeft);
    if (onLeft) leftIn = 1'b1; else rightIn = 1'b1;
    cyc(1);
    leftIn = 1'b0; rightIn = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; dirFwd = 1'b1; modeGroup = 1'b1; bankSel = 1'b0;
    leftIn = 1'b0; rightIn = 1'b0;
    cyc(3);                              // R11 reset state
    rstN = 1'b1;
    cyc(2);
    pulse(1); cyc(90);                   // R3 group forward
    dirFwd = 1'b0; cyc(2);
    pulse(0); cyc(90);                   // R3 group reverse, R2 swapped roles
    modeGroup = 1'b0; dirFwd = 1'b1; cyc(2);
    pulse(1); cyc(250);                  // R4 R5 single forward
    dirFwd = 1'b0; cyc(2);
    pulse(0); cyc(250);                  // R5 single reverse
    dirFwd = 1'b1; modeGroup = 1'b1;
    pulse(1); cyc(1); pulse(1); cyc(20); // R10 start during lead-in and scan
    pulse(1); modeGroup = 1'b0; cyc(70); // R10 mode change mid-scan has no effect
    pulse(0); cyc(6);                    // R10 pulse on the output pin
    modeGroup = 1'b1; pulse(1); cyc(10);
    bankSel = 1'b1; cyc(4);              // R9 change while scanning
    bankSel = 1'b0; cyc(80);
    bankSel = 1'b1; cyc(4);              // R9 change while idle: no flag, R8 swap
    modeGroup = 1'b0; pulse(1); cyc(50);
    rstN = 1'b0; cyc(2);                 // R11 reset mid-scan
    rstN = 1'b1; cyc(10);
    modeGroup = 1'b1; leftIn = 1'b1; cyc(200);  // held start restarts after idle
    leftIn = 1'b0; cyc(90);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule